// File: doc/BRIEF.md
# Key-Combination Reset Generator

This block turns a held combination of keypad keys and general-purpose inputs into a system reset request. It watches the live state of every key and input. When all the conditions programmed for one of its two reset outputs are met in the same clock cycle, it drives that output to its asserted level. Key scanning and input debouncing happen upstream. This block only sees clean, per-cycle state vectors.

Software writes condition slots through a small write port. Output 1 has three slots and output 2 has two. Each slot byte carries a required level in bit 7 and an event code in bits 6:0. Event code 0 switches the slot off. A configuration byte selects the active polarity of each output. It also lets an external reset request be merged into output 1.

Top module: `kcr_reset_gen`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr` on that clock edge. Addresses 0, 1 and 2 hold output-1 slots A, B and C. Addresses 3 and 4 hold output-2 slots A and B. Address 5 holds the configuration byte. In a slot byte, bit 7 is the required level and bits 6:0 are the event code. A write to one address leaves every other address unchanged.
- R2: A slot whose event code (bits 6:0) is zero is disabled and takes no part in its output's condition, whatever its level bit.
- R3: An output's event condition is true only when it has at least one enabled slot and every one of its enabled slots is satisfied in the same cycle.
- R4: Event codes 1 to NUM_KEYS (default 25) select `key_state[code-1]`, where 1 means pressed. With level 1 the slot is satisfied while that key is pressed. With level 0 the slot is never satisfied, because a release never causes a reset.
- R5: Event codes GPI_BASE to GPI_BASE+NUM_GPI-1 (defaults 37 to 47) select `gpi_state[code-GPI_BASE]`, where 1 means active. Level 1 is satisfied while the input is active. Level 0 is satisfied while it is inactive.
- R6: An event code in neither range (for example 30) is never satisfied.
- R7: An output whose slots are all disabled never asserts from events.
- R8: The asserted state is registered. An output asserts on the first clock edge after its condition becomes true and deasserts on the first edge after it clears. A slot write takes effect on its own edge, so it reaches the output one edge later.
- R9: Configuration bit 6 sets the polarity of output 1 and bit 7 sets the polarity of output 2. With 0 the pin is driven low when asserted. With 1 the pin is driven high when asserted. A polarity change shows on the pin on the edge that writes it.
- R10: When configuration bit 5 is 1, `ext_rst_req` is ORed into output 1's asserted state, with the same one-edge timing. When bit 5 is 0, the request has no effect. It never affects output 2.
- R11: Block reset (`rst_n` low) clears every slot and the configuration byte. Both outputs are then inactive and active low, so both pins read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | 8 | Register write data |
| key_state | input | NUM_KEYS (25) | Live key state, 1 = pressed |
| gpi_state | input | NUM_GPI (11) | Live general-input state, 1 = active |
| ext_rst_req | input | 1 | External reset request, active high |
| rst1_pin | output | 1 | Reset output 1, polarity per config bit 6 |
| rst2_pin | output | 1 | Reset output 2, polarity per config bit 7 |

## Verification
Some rules are checked by assertions on every cycle:
- a key slot with level 0 blocks its output;
- an output with no enabled slot stays idle;
- an external request with pass-through enabled asserts output 1 on the next edge;
- output 2 falls idle whenever its own condition is false;
- the configuration address never disturbs the slot bytes;
- both pins read inactive when reset is released.

Other behaviour only the bench scenarios can show. These are the all-slots-at-once rule under partial matches, the inverted level on a general input, unmapped codes, slot disabling by a zero code, polarity flips and the one-cycle assert and release timing. They are all compared against a model that the bench builds from the slot bytes it wrote.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

    typedef struct packed {
        logic       level;
        logic [6:0] code;
    } kcr_slot_t;

    typedef struct packed {
        logic       pol2;
        logic       pol1;
        logic       pass_en;
        logic [4:0] unused;
    } kcr_cfg_t;

endpackage

// File: rtl/kcr_slot_match.sv
module kcr_slot_match
    import kcr_pkg::*;
#(
    parameter int NUM_KEYS = 25,
    parameter int NUM_GPI  = 11,
    parameter int GPI_BASE = 37
) (
    input  kcr_slot_t           slot,
    input  logic [NUM_KEYS-1:0] key_state,
    input  logic [NUM_GPI-1:0]  gpi_state,
    output logic                en,
    output logic                hit
);

    always_comb begin
        en  = (slot.code != 7'd0);
        hit = 1'b0;
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (slot.code == 7'(k + 1)) begin
                hit = slot.level & key_state[k];
            end
        end
        for (int g = 0; g < NUM_GPI; g++) begin
            if (slot.code == 7'(GPI_BASE + g)) begin
                hit = (gpi_state[g] == slot.level);
            end
        end
    end

endmodule

// File: rtl/kcr_combiner.sv
module kcr_combiner
    import kcr_pkg::*;
#(
    parameter int NSLOT    = 3,
    parameter int NUM_KEYS = 25,
    parameter int NUM_GPI  = 11,
    parameter int GPI_BASE = 37
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  kcr_slot_t [NSLOT-1:0]  slots,
    input  logic [NUM_KEYS-1:0]    key_state,
    input  logic [NUM_GPI-1:0]     gpi_state,
    output logic                   cond
);

    logic [NSLOT-1:0] en_v;
    logic [NSLOT-1:0] hit_v;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        kcr_slot_match #(
            .NUM_KEYS (NUM_KEYS),
            .NUM_GPI  (NUM_GPI),
            .GPI_BASE (GPI_BASE)
        ) u_match (
            .slot      (slots[i]),
            .key_state (key_state),
            .gpi_state (gpi_state),
            .en        (en_v[i]),
            .hit       (hit_v[i])
        );
    end

    assign cond = (|en_v) && (&(hit_v | ~en_v));

    logic key_release_slot;
    always_comb begin
        key_release_slot = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (int'(slots[i].code) >= 1 && int'(slots[i].code) <= NUM_KEYS
                && !slots[i].level) begin
                key_release_slot = 1'b1;
            end
        end
    end

    // R4
    key_lvl0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_release_slot |-> !cond);

endmodule

// File: rtl/kcr_regs.sv
module kcr_regs
    import kcr_pkg::*;
#(
    parameter int N1     = 3,
    parameter int N2     = 2,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    output kcr_slot_t [N1-1:0]  slots1,
    output kcr_slot_t [N2-1:0]  slots2,
    output kcr_cfg_t            cfg
);

    localparam int CFG_ADDR = N1 + N2;

    typedef struct packed {
        kcr_slot_t [N1-1:0] s1;
        kcr_slot_t [N2-1:0] s2;
        kcr_cfg_t           cfg;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < N1; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    st_d.s1[i] = kcr_slot_t'(wr_data);
                end
            end
            for (int i = 0; i < N2; i++) begin
                if (wr_addr == ADDR_W'(N1 + i)) begin
                    st_d.s2[i] = kcr_slot_t'(wr_data);
                end
            end
            if (wr_addr == ADDR_W'(CFG_ADDR)) begin
                st_d.cfg = kcr_cfg_t'({wr_data[7:5], 5'd0});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slots1 = st_q.s1;
    assign slots2 = st_q.s2;
    assign cfg    = st_q.cfg;

    // R1
    cfg_wr_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CFG_ADDR)) |=> ($stable(slots1) && $stable(slots2)));

endmodule

// File: rtl/kcr_reset_gen.sv
module kcr_reset_gen
    import kcr_pkg::*;
#(
    parameter int NUM_KEYS = 25,
    parameter int NUM_GPI  = 11,
    parameter int GPI_BASE = 37,
    parameter int N1       = 3,
    parameter int N2       = 2,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [NUM_KEYS-1:0] key_state,
    input  logic [NUM_GPI-1:0]  gpi_state,
    input  logic                ext_rst_req,
    output logic                rst1_pin,
    output logic                rst2_pin
);

    kcr_slot_t [N1-1:0] slots1;
    kcr_slot_t [N2-1:0] slots2;
    kcr_cfg_t           cfg_q;
    logic               cond1, cond2;

    kcr_regs #(
        .N1     (N1),
        .N2     (N2),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .slots1  (slots1),
        .slots2  (slots2),
        .cfg     (cfg_q)
    );

    kcr_combiner #(
        .NSLOT    (N1),
        .NUM_KEYS (NUM_KEYS),
        .NUM_GPI  (NUM_GPI),
        .GPI_BASE (GPI_BASE)
    ) u_comb1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slots     (slots1),
        .key_state (key_state),
        .gpi_state (gpi_state),
        .cond      (cond1)
    );

    kcr_combiner #(
        .NSLOT    (N2),
        .NUM_KEYS (NUM_KEYS),
        .NUM_GPI  (NUM_GPI),
        .GPI_BASE (GPI_BASE)
    ) u_comb2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slots     (slots2),
        .key_state (key_state),
        .gpi_state (gpi_state),
        .cond      (cond2)
    );

    typedef struct packed {
        logic act1;
        logic act2;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.act1 = cond1 | (cfg_q.pass_en & ext_rst_req);
        out_d.act2 = cond2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rst1_pin = cfg_q.pol1 ? out_q.act1 : ~out_q.act1;
    assign rst2_pin = cfg_q.pol2 ? out_q.act2 : ~out_q.act2;

    logic out2_no_slot;
    always_comb begin
        out2_no_slot = 1'b1;
        for (int i = 0; i < N2; i++) begin
            if (slots2[i].code != 7'd0) out2_no_slot = 1'b0;
        end
    end

    // R10
    ext_to_out1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.pass_en && ext_rst_req) |=> out_q.act1);

    // R10
    out2_ext_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond2 |=> !out_q.act2);

    // R7
    out2_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out2_no_slot |=> !out_q.act2);

    // R11
    reset_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rst1_pin && rst2_pin));

endmodule

// File: tb/kcr_reset_gen_tb.sv
`timescale 1ns/1ps
module kcr_reset_gen_tb;

    localparam int NK    = 25;
    localparam int NG    = 11;
    localparam int GBASE = 37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NK-1:0] key_state = '0;
    logic [NG-1:0] gpi_state = '0;
    logic          ext_rst_req = 1'b0;
    logic          rst1_pin, rst2_pin;

    always #2.5 clk = ~clk;

    kcr_reset_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .key_state   (key_state),
        .gpi_state   (gpi_state),
        .ext_rst_req (ext_rst_req),
        .rst1_pin    (rst1_pin),
        .rst2_pin    (rst2_pin)
    );

    typedef struct {
        logic  e1;
        logic  e2;
        string tag;
    } exp_t;

    exp_t      sb_q[$];
    int        total = 0;
    int        bad   = 0;
    bit        done  = 1'b0;
    logic [7:0] m_reg [6];

    function automatic bit slot_ok(logic [7:0] s);
        int c = int'(s[6:0]);
        if (c >= 1 && c <= NK) return s[7] && key_state[c-1];
        if (c >= GBASE && c < GBASE + NG) return gpi_state[c-GBASE] == s[7];
        return 1'b0;
    endfunction

    function automatic bit cond_of(int first, int n);
        bit any = 0;
        bit all = 1;
        for (int i = first; i < first + n; i++) begin
            if (m_reg[i][6:0] != 0) begin
                any = 1;
                if (!slot_ok(m_reg[i])) all = 0;
            end
        end
        return any && all;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 6; i++) m_reg[i] = 8'h00;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = d;
        @(posedge clk);
        m_reg[a] = (a == 5) ? {d[7:5], 5'd0} : d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_after(input int edges, input string tag);
        exp_t it;
        bit a1, a2;
        repeat (edges) @(posedge clk);
        a1 = cond_of(0, 3) | (m_reg[5][5] & ext_rst_req);
        a2 = cond_of(3, 2);
        it.e1  = m_reg[5][6] ? a1 : !a1;
        it.e2  = m_reg[5][7] ? a2 : !a2;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                total++;
                if (rst1_pin !== it.e1 || rst2_pin !== it.e2) begin
                    bad++;
                    $display("FAIL %s: pins actual=%b%b expected=%b%b",
                             it.tag, rst1_pin, rst2_pin, it.e1, it.e2);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_after(1, "R11 reset state");

        key_state[0] = 1'b1;
        expect_after(2, "R7 no enabled slot");
        ext_rst_req = 1'b1;
        expect_after(2, "R10 pass-through off");
        ext_rst_req = 1'b0;

        wr(0, {1'b1, 7'd1});
        expect_after(1, "R1 R4 key press slot A");
        key_state[0] = 1'b0;
        expect_after(1, "R8 deassert next edge");
        key_state[0] = 1'b1;
        expect_after(1, "R8 assert next edge");

        wr(1, {1'b1, 7'd5});
        expect_after(1, "R3 partial match");
        key_state[4] = 1'b1;
        expect_after(2, "R3 two slots met");

        wr(2, {1'b1, 7'd37});
        expect_after(1, "R3 third slot unmet");
        gpi_state[0] = 1'b1;
        expect_after(2, "R5 active input level 1");

        wr(2, {1'b0, 7'd38});
        expect_after(1, "R5 inactive input level 0");
        gpi_state[1] = 1'b1;
        expect_after(2, "R5 level 0 input active");
        gpi_state[1] = 1'b0;

        wr(1, 8'h80);
        key_state[4] = 1'b0;
        expect_after(2, "R2 zero code slot ignored");

        wr(2, {1'b1, 7'd30});
        expect_after(2, "R6 unmapped code");
        wr(2, 8'h00);

        wr(0, {1'b0, 7'd1});
        expect_after(2, "R4 key level 0 pressed");
        key_state[0] = 1'b0;
        expect_after(2, "R4 key level 0 released");

        wr(0, {1'b1, 7'd1});
        key_state[0] = 1'b1;
        expect_after(2, "R4 active low assert");
        wr(5, 8'h40);
        expect_after(0, "R9 polarity out1 at write edge");

        wr(5, 8'h60);
        key_state[0] = 1'b0;
        expect_after(2, "R10 idle with pass-through");
        ext_rst_req = 1'b1;
        expect_after(1, "R10 pin merged into out1");

        wr(3, {1'b1, 7'd2});
        wr(4, {1'b1, 7'd40});
        expect_after(1, "R3 out2 unmet, R10 ext not on out2");
        key_state[1] = 1'b1;
        gpi_state[3] = 1'b1;
        expect_after(2, "R3 out2 both slots met");
        wr(5, 8'hE0);
        expect_after(0, "R9 polarity out2");
        gpi_state[3] = 1'b0;
        expect_after(1, "R8 out2 release");

        rst_n = 1'b0;
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
        expect_after(1, "R11 reset mid-run");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule